// File: doc/BRIEF.md
# Converter Sample Queue with Status/Control Register

This block buffers results from an analog-to-digital converter until a host processor collects them. Each result is a 12-bit sample plus a flag that marks it as out of range. A result enters at the top of an eight-word shift queue. The host reads the word at location 0. That read pops the queue, and every remaining word moves one place toward location 0. A 12-bit parallel bus with one address line lets the host reach both the queue and a status/control register. Through the register the host sets an almost-full threshold and can mask the active-low almost-full pin. The register also reports overrun, out-of-range, empty and the word count, and writing it can start a full soft reset.

Samples arrive as a stream with `in_valid`, one result per asserted cycle. The stream has no ready signal and no back-pressure, because the converter cannot be stalled. If the queue is full when a result arrives, that result is dropped and the drop is recorded. Everything happens on one clock. A bus access is a single-cycle enable: `bus_sel` together with `bus_rd` or `bus_wr`.

Top module: `sample_fifo_sreg`

## Requirements
- R1: After reset, the status word is 0xF10. This means almost-full pin high (bit 11), threshold 7 in bits 10:8, mask 0 in bit 7, overrun 0 in bit 6, sticky range 0 in bit 5, empty 1 in bit 4, head range flag 0 in bit 3, and count field 0 in bits 2:0. `almost_full_n` is 1.
- R2: A bus read with `bus_addr`=0 returns location 0 on `bus_rdata` in the same cycle, and it pops that word at the clock edge. Words come out in arrival order.
- R3: A result that arrives while eight words are held is dropped, and the count does not change. The overrun bit (bit 6) sets and stays set until a reset.
- R4: When the queue is empty, a pop changes nothing. `bus_rdata` keeps showing the last word that was held in location 0, and the empty bit (bit 4) reads 1.
- R5: Bits 2:0 read as the number of held words minus one, or 0 when the queue is empty.
- R6: The almost-full state is recomputed only on a cycle with `in_valid`. It becomes true when the post-push count field equals the threshold in bits 10:8, and false otherwise. The threshold and mask used are the values held before that edge. Pops and register writes do not recompute it. `almost_full_n` and bit 11 are 0 only while the state is true and unmasked.
- R7: Bit 7 written as 1 immediately forces `almost_full_n` and bit 11 to 1. Writing it back to 0 exposes the stored state again.
- R8: A register write (`bus_addr`=1) with bit 6 set resets everything to the R1 state, including the stored words. It takes priority over a push arriving in the same cycle.
- R9: Bit 5 is sticky. It sets when an accepted result carries the range flag, and it clears only on a reset. Bit 3 shows the range flag of the word in location 0.
- R10: A register read never moves queue data. A register write changes only bits 10:7, and the value written to bits 11, 5:0 has no effect.
- R11: A pop and a push in the same cycle complete the pop first. The new word lands on the new top and the count is unchanged. When the queue is empty, the push alone takes effect.
- R12: `in_valid` on consecutive cycles accepts one result per cycle while space remains. There is no ready signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A converter result is present this cycle |
| in_data | input | 12 | Converter sample |
| in_oor | input | 1 | Sample is out of range |
| bus_sel | input | 1 | Bus chip select, active high |
| bus_rd | input | 1 | Bus read enable |
| bus_wr | input | 1 | Bus write enable |
| bus_addr | input | 1 | 1 selects the register, 0 selects the queue |
| bus_wdata | input | 12 | Register write data |
| bus_rdata | output | 12 | Register or location 0 contents |
| almost_full_n | output | 1 | Almost-full indication, active low |

## Verification
The hardest case to reach is the exact cycle where the queue is at eight words and a push, a pop and sometimes a register write all land together. Each of these changes the count, the stored almost-full state and the overrun flag in a different order. Random stimulus with a high push rate and a moderate pop rate keeps the queue near full for long stretches. Directed sequences fill the queue past capacity, drain it past empty, and hit push-with-pop on both a full and an empty queue. A rare random soft-reset write makes the random run cross the reset path many times.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int unsigned SF_DW    = 12;
  localparam int unsigned SF_DEPTH = 8;
  localparam int unsigned SF_BUS_W = 12;

  // status/control word layout
  localparam int unsigned ST_AFN     = 11;
  localparam int unsigned ST_AFC_LO  = 8;
  localparam int unsigned ST_MASK    = 7;
  localparam int unsigned ST_OVR     = 6;
  localparam int unsigned ST_OOR     = 5;
  localparam int unsigned ST_EMPTY   = 4;
  localparam int unsigned ST_HEADOOR = 3;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_POP   = 2'd1,
    ACC_REGRD = 2'd2,
    ACC_REGWR = 2'd3
  } acc_e;
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int unsigned DW    = 12,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH),
  localparam int unsigned WW   = DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [WW-1:0] push_word,
  input  logic          pop,
  output logic [CW:0]   cnt,
  output logic [CW:0]   cnt_next,
  output logic [WW-1:0] head,
  output logic          taken,
  output logic          dropped
);
  localparam logic [CW:0] FULL_CNT = (CW+1)'(DEPTH);

  logic [WW-1:0] mem [DEPTH];
  logic          pop_eff;
  logic          shift;
  logic [CW:0]   base;

  always_comb begin
    pop_eff  = pop && (cnt != '0);
    shift    = pop_eff && (cnt > (CW+1)'(1));
    base     = cnt - (CW+1)'(pop_eff);
    taken    = push && (base != FULL_CNT);
    dropped  = push && !taken;
    cnt_next = base + (CW+1)'(taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt_next;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_loc
    if (g < DEPTH - 1) begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               mem[g] <= '0;
        else if (clr)                             mem[g] <= '0;
        else if (taken && base == (CW+1)'(g))     mem[g] <= push_word;
        else if (shift)                           mem[g] <= mem[g+1];
      end
    end else begin : g_top
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               mem[g] <= '0;
        else if (clr)                             mem[g] <= '0;
        else if (taken && base == (CW+1)'(g))     mem[g] <= push_word;
      end
    end
  end

  assign head = mem[0];
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned BUS_W = 12,
  localparam int unsigned CW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             conv_end,
  input  logic [CW:0]      cnt_next,
  input  logic             taken,
  input  logic             dropped,
  input  logic             push_oor,
  output logic [CW-1:0]    afc,
  output logic             mask,
  output logic             ovr,
  output logic             oor_sticky,
  output logic             af_hit,
  output logic             soft_clr
);
  logic [CW-1:0] field_next;

  always_comb begin
    soft_clr   = reg_wr && wdata[ST_OVR];
    field_next = (cnt_next == '0) ? '0 : CW'(cnt_next - (CW+1)'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      afc <= '1; mask <= 1'b0; ovr <= 1'b0; oor_sticky <= 1'b0; af_hit <= 1'b0;
    end else if (soft_clr) begin
      afc <= '1; mask <= 1'b0; ovr <= 1'b0; oor_sticky <= 1'b0; af_hit <= 1'b0;
    end else begin
      if (reg_wr) begin
        afc  <= wdata[ST_AFC_LO +: CW];
        mask <= wdata[ST_MASK];
      end
      if (dropped)             ovr        <= 1'b1;
      if (taken && push_oor)   oor_sticky <= 1'b1;
      if (conv_end)            af_hit     <= (field_next == afc);
    end
  end
endmodule

// File: rtl/sfifo_bus.sv
module sfifo_bus
  import sfifo_pkg::*;
#(
  parameter int unsigned DW    = 12,
  parameter int unsigned BUS_W = 12
) (
  input  logic             sel,
  input  logic             rd,
  input  logic             wr,
  input  logic             addr,
  input  logic [BUS_W-1:0] status,
  input  logic [DW-1:0]    head_data,
  output logic             fifo_pop,
  output logic             reg_wr,
  output logic [BUS_W-1:0] rdata
);
  acc_e acc;

  always_comb begin
    acc = ACC_IDLE;
    if (sel) begin
      if (addr && wr)       acc = ACC_REGWR;
      else if (addr && rd)  acc = ACC_REGRD;
      else if (!addr && rd) acc = ACC_POP;
    end
    fifo_pop = (acc == ACC_POP);
    reg_wr   = (acc == ACC_REGWR);
    rdata    = addr ? status : BUS_W'(head_data);
  end
endmodule

// File: rtl/sample_fifo_sreg.sv
module sample_fifo_sreg
  import sfifo_pkg::*;
#(
  parameter int unsigned DW    = SF_DW,
  parameter int unsigned DEPTH = SF_DEPTH,
  parameter int unsigned BUS_W = SF_BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic             in_oor,
  input  logic             bus_sel,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             almost_full_n
);
  localparam int unsigned CW = $clog2(DEPTH);
  localparam int unsigned WW = DW + 1;

  logic          fifo_pop, reg_wr, soft_clr;
  logic [CW:0]   cnt, cnt_next;
  logic [WW-1:0] head;
  logic          taken, dropped;
  logic [CW-1:0] afc, cnt_field;
  logic          mask, ovr, oor_sticky, af_hit;
  logic [BUS_W-1:0] status;

  sfifo_bus #(.DW(DW), .BUS_W(BUS_W)) u_bus (
    .sel(bus_sel), .rd(bus_rd), .wr(bus_wr), .addr(bus_addr),
    .status(status), .head_data(head[DW-1:0]),
    .fifo_pop(fifo_pop), .reg_wr(reg_wr), .rdata(bus_rdata)
  );

  sfifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr),
    .push(in_valid), .push_word({in_oor, in_data}), .pop(fifo_pop),
    .cnt(cnt), .cnt_next(cnt_next), .head(head),
    .taken(taken), .dropped(dropped)
  );

  sfifo_ctrl #(.DEPTH(DEPTH), .BUS_W(BUS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wdata(bus_wdata),
    .conv_end(in_valid), .cnt_next(cnt_next), .taken(taken),
    .dropped(dropped), .push_oor(in_oor),
    .afc(afc), .mask(mask), .ovr(ovr), .oor_sticky(oor_sticky),
    .af_hit(af_hit), .soft_clr(soft_clr)
  );

  always_comb begin
    cnt_field     = (cnt == '0) ? '0 : CW'(cnt - (CW+1)'(1));
    almost_full_n = !(af_hit && !mask);
    status                        = '0;
    status[ST_AFN]                = almost_full_n;
    status[ST_AFC_LO +: CW]       = afc;
    status[ST_MASK]               = mask;
    status[ST_OVR]                = ovr;
    status[ST_OOR]                = oor_sticky;
    status[ST_EMPTY]              = (cnt == '0);
    status[ST_HEADOOR]            = head[WW-1];
    status[CW-1:0]                = cnt_field;
  end
endmodule

// File: rtl/sample_fifo_sreg_chk.sv
module sample_fifo_sreg_chk #(
  parameter int unsigned DW    = 12,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          fifo_pop,
  input logic          soft_clr,
  input logic [CW:0]   cnt,
  input logic [DW:0]   head,
  input logic          af_hit,
  input logic          ovr,
  input logic          oor_sticky
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (CW+1)'(DEPTH));

  assert_drop_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == (CW+1)'(DEPTH) && in_valid && !fifo_pop && !soft_clr)
      |=> (cnt == (CW+1)'(DEPTH) && ovr));

  assert_ovr_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !soft_clr) |=> ovr);

  assert_oor_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (oor_sticky && !soft_clr) |=> oor_sticky);

  assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !in_valid && !soft_clr) |=> $stable(head));

  assert_af_on_push_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !soft_clr) |=> $stable(af_hit));

  assert_no_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !fifo_pop && !soft_clr) |=> ($stable(cnt) && $stable(head)));

  assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (cnt == '0 && !ovr && !oor_sticky && !af_hit));

  assert_push_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fifo_pop && cnt != '0 && !soft_clr) |=> $stable(cnt));
endmodule

bind sample_fifo_sreg sample_fifo_sreg_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fifo_pop(fifo_pop),
  .soft_clr(soft_clr), .cnt(cnt), .head(head), .af_hit(af_hit),
  .ovr(ovr), .oor_sticky(oor_sticky)
);

// File: tb/sample_fifo_sreg_tb.sv
`timescale 1ns/1ps
module sample_fifo_sreg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_data = '0;
  logic        in_oor = 1'b0;
  logic        bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [11:0] bus_wdata = '0;
  logic [11:0] bus_rdata;
  logic        almost_full_n;

  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  sample_fifo_sreg u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_oor(in_oor), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .almost_full_n(almost_full_n)
  );

  // reference model
  logic [12:0] q [8];
  int          qc;
  bit          m_ovr, m_oor, m_afhit, m_mask;
  logic [2:0]  m_afc;

  function automatic void model_reset();
    for (int i = 0; i < 8; i++) q[i] = '0;
    qc = 0; m_ovr = 0; m_oor = 0; m_afhit = 0; m_mask = 0; m_afc = 3'd7;
  endfunction

  function automatic logic [2:0] field_of(int c);
    return (c == 0) ? 3'd0 : 3'(c - 1);
  endfunction

  function automatic bit exp_afn();
    return !(m_afhit && !m_mask);
  endfunction

  function automatic logic [11:0] exp_status();
    return {exp_afn(), m_afc, m_mask, m_ovr, m_oor, (qc == 0), q[0][12], field_of(qc)};
  endfunction

  function automatic void model_step(bit v, logic [11:0] d, bit o, bit sel, bit rd,
                                     bit wr, bit addr, logic [11:0] wd);
    bit pop, rw;
    logic [2:0] old_afc;
    pop = sel && rd && !addr;
    rw  = sel && wr && addr;
    if (rw && wd[6]) begin model_reset(); return; end
    old_afc = m_afc;
    if (pop && qc > 0) begin
      if (qc > 1) for (int i = 0; i < 7; i++) q[i] = q[i+1];
      qc--;
    end
    if (v) begin
      if (qc < 8) begin q[qc] = {o, d}; qc++; if (o) m_oor = 1; end
      else m_ovr = 1;
      m_afhit = (field_of(qc) == old_afc);
    end
    if (rw) begin m_afc = wd[10:8]; m_mask = wd[7]; end
  endfunction

  task automatic check(logic [11:0] act, logic [11:0] exp, string req);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%03h expected 0x%03h at %0t", req, act, exp, $time);
    end
  endtask

  // one bus/stream cycle: drive, check pre-edge outputs, advance model
  task automatic cyc(bit v, logic [11:0] d, bit o, bit sel, bit rd, bit wr,
                     bit addr, logic [11:0] wd, string req);
    in_valid = v; in_data = d; in_oor = o;
    bus_sel = sel; bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    #1;
    check(bus_rdata, addr ? exp_status() : {q[0][11:0]}, req);
    check({11'd0, almost_full_n}, {11'd0, exp_afn()}, req);
    @(posedge clk);
    model_step(v, d, o, sel, rd, wr, addr, wd);
    @(negedge clk);
  endtask

  task automatic push_st(logic [11:0] d, bit o, string req);
    cyc(1, d, o, 1, 1, 0, 1, 12'h000, req);
  endtask
  task automatic pop_rd(string req);
    cyc(0, 12'h000, 0, 1, 1, 0, 0, 12'h000, req);
  endtask
  task automatic st_rd(string req);
    cyc(0, 12'h000, 0, 1, 1, 0, 1, 12'h000, req);
  endtask
  task automatic reg_wr(logic [11:0] wd, string req);
    cyc(0, 12'h000, 0, 1, 0, 1, 1, wd, req);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    #1; check(bus_rdata, 12'h000, "R1 fifo head after reset");
    st_rd("R1");
    check(exp_status(), 12'hF10, "R1 model");
    bus_addr = 1; #1; check(bus_rdata, 12'hF10, "R1 status value");
    // R4: pop on empty does nothing
    pop_rd("R4");
    st_rd("R4");

    // R12 burst fill, R3 overflow, R9 range flags
    for (int i = 0; i < 9; i++) push_st(12'h100 + 12'(i), (i == 2), "R12 R3 R9");
    st_rd("R3 overrun set");
    bus_addr = 1; #1;
    check(bus_rdata[6], 1'b1, "R3 overrun bit");
    check(bus_rdata[2:0], 3'd7, "R5 full count");
    check(bus_rdata[5], 1'b1, "R9 sticky range");
    check({11'd0, almost_full_n}, 12'd0, "R6 flag at threshold 7");

    // R2 drain in order, R9 head flag, R4 last word kept
    for (int i = 0; i < 8; i++) begin
      st_rd("R9 head flag");
      pop_rd("R2 order");
    end
    pop_rd("R4 empty read");
    bus_addr = 0; #1; check(bus_rdata, 12'h107, "R4 last word held");
    st_rd("R4 R5 empty status");
    check(bus_rdata[4], 1'b1, "R4 empty bit");

    // R6 threshold equality and update only on push; R10 ro bits ignored
    reg_wr(12'b0000_0011_1111 | 12'h300, "R10 write with ro bits");
    st_rd("R10 readback");
    bus_addr = 1; #1; check(bus_rdata[10:7], 4'b0110, "R10 writable bits");
    for (int i = 0; i < 4; i++) push_st(12'h200 + 12'(i), 0, "R6 fill");
    #1; check({11'd0, almost_full_n}, 12'd0, "R6 low at four words");
    pop_rd("R6 pop keeps flag");
    #1; check({11'd0, almost_full_n}, 12'd0, "R6 not re-evaluated on pop");
    push_st(12'h210, 0, "R6");
    push_st(12'h211, 0, "R6 past threshold");
    #1; check({11'd0, almost_full_n}, 12'd1, "R6 high when not equal");

    // R7 mask
    reg_wr(12'h280, "R7 mask on");
    reg_wr(12'h500, "R7 unmask threshold 5");
    push_st(12'h212, 0, "R7");
    #1; check({11'd0, almost_full_n}, 12'd0, "R7 exposed flag");
    reg_wr(12'h580, "R7 mask");
    #1; check({11'd0, almost_full_n}, 12'd1, "R7 masked immediately");
    st_rd("R7 bit 11");

    // R11 push+pop together (nonempty, full, empty)
    cyc(1, 12'h333, 0, 1, 1, 0, 0, 12'h000, "R11 push pop");
    st_rd("R11 count kept");
    for (int i = 0; i < 3; i++) push_st(12'h340 + 12'(i), 1, "R11 fill");
    cyc(1, 12'h355, 0, 1, 1, 0, 0, 12'h000, "R11 full push pop");
    st_rd("R11 no overrun");
    // R8 soft reset beats push
    cyc(1, 12'h777, 1, 1, 0, 1, 1, 12'h040, "R8 soft reset");
    st_rd("R8 status after soft reset");
    bus_addr = 1; #1; check(bus_rdata, 12'hF10, "R8 back to reset word");
    bus_addr = 0; #1; check(bus_rdata, 12'h000, "R8 data cleared");
    cyc(1, 12'h0AB, 1, 1, 1, 0, 0, 12'h000, "R11 push pop on empty");
    st_rd("R11 empty push lands");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit v, sel, rd, wr, addr, o;
      logic [11:0] d, wd;
      v    = ($urandom_range(0, 99) < 60);
      sel  = ($urandom_range(0, 99) < 80);
      addr = $urandom_range(0, 1);
      rd   = ($urandom_range(0, 99) < 55);
      wr   = ($urandom_range(0, 99) < 8);
      o    = ($urandom_range(0, 99) < 10);
      d    = 12'($urandom);
      wd   = 12'($urandom) & ~12'h040;
      if ($urandom_range(0, 199) == 0) wd[6] = 1'b1;
      cyc(v, d, o, sel, rd, wr, addr, wd, "R2 R5 R6 R11 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule